// File: doc/BRIEF.md
# Column-matrix readout sequencer

This block schedules the readout of a stopped circular sample matrix. The matrix holds 128 columns for each of four channels. When a start pulse arrives, the block captures its configuration and then emits an ordered stream of read requests over a valid/ready handshake. The configuration is the stop column, a column count, two fast-mode controls and a channel mask. Each read request names one channel and one column. The block holds no sample storage. A downstream reader uses each request word to fetch the matching cell.

A frame can begin with a header word that carries the captured trigger-position value. The fast controls can drop this header. They also choose whether the column walk starts at column 0 or at the stop column. From the stop column, addresses wrap round the 128-column ring. Masked channels are left out of the frame completely, so the frame is shorter. A one-cycle done pulse closes every frame.

Top module: `col_readout_seq`

## Requirements
- R1: While reset is held and just after it is released, out_valid and done are both 0.
- R2: If skip_tpos is 0 at start, the first word of the frame is a header: out_hdr is 1 and out_tpos equals the tpos_in value captured at start. If skip_tpos is 1, the frame contains no header word.
- R3: If from_stop is 0, the first data column is 0. If from_stop is 1, the first data column is stop_col, and later columns count up modulo 128.
- R4: The column count is taken as min(col_count, 128). A count of 0 emits only the optional header and then the done pulse.
- R5: Within a column, data words go only to channels whose ch_mask bit is 1, in ascending channel number (bit i is channel i). An all-zero mask emits no data words.
- R6: Columns come out in increasing address order, and exactly the clamped count of distinct columns is emitted, each with out_hdr = 0.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and the word (out_hdr, out_chan, out_col, out_tpos) stays unchanged.
- R8: done is 1 for exactly one cycle. That cycle is the one after the last word is accepted, or the cycle after start if the frame is empty.
- R9: A start pulse that arrives while a frame is in progress, including its done cycle, is ignored. The running frame keeps the configuration captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a frame when idle |
| stop_col | input | 7 | Column where the matrix stopped |
| col_count | input | 8 | Requested number of columns |
| skip_tpos | input | 1 | 1 drops the header word |
| from_stop | input | 1 | 1 starts the walk at stop_col |
| ch_mask | input | 4 | Per-channel enable |
| tpos_in | input | 8 | Trigger-position value for the header |
| out_ready | input | 1 | Consumer accepts the current word |
| out_valid | output | 1 | A word is presented |
| out_hdr | output | 1 | Current word is the header |
| out_chan | output | 2 | Channel of a data word |
| out_col | output | 7 | Column of a data word |
| out_tpos | output | 8 | Captured trigger position |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions treat out_ready as a free input. They do not require a consumer to hold ready once it raises it. Likewise, start may arrive in any state and col_count may take any 8-bit value. No legality is assumed of any input beyond its width. The stimulus drives ready from a pseudo-random stall pattern and uses counts above 128, a zero count and a zero mask. During one frame it also raises a stray start with a different configuration, so the checks are exercised on the stall, clamp and ignore paths.

// File: rtl/colseq_pkg.sv
`timescale 1ns/1ps
package colseq_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_HDR  = 2'd1,
    S_DATA = 2'd2,
    S_FIN  = 2'd3
  } seq_state_t;

  // index of the lowest set bit, -1 if none
  function automatic int lowest_idx(input logic [31:0] v);
    int r;
    r = -1;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/colseq_cfg.sv
`timescale 1ns/1ps
module colseq_cfg #(
  parameter int NCOLS = 128,
  parameter int NCH   = 4,
  parameter int CNTW  = 8,
  parameter int TPW   = 8,
  localparam int COLW = $clog2(NCOLS),
  localparam int CHW  = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [COLW-1:0] stop_col,
  input  logic [CNTW-1:0] col_count,
  input  logic            from_stop,
  input  logic [NCH-1:0]  ch_mask,
  input  logic [TPW-1:0]  tpos_in,
  output logic [CNTW-1:0] cnt_q,
  output logic [COLW-1:0] base_q,
  output logic [NCH-1:0]  mask_q,
  output logic [TPW-1:0]  tpos_q,
  output logic            ld_words,
  output logic [CHW-1:0]  ld_first
);
  import colseq_pkg::*;

  function automatic logic [CNTW-1:0] clamp_cnt(input logic [CNTW-1:0] c);
    return (c > CNTW'(NCOLS)) ? CNTW'(NCOLS) : c;
  endfunction

  int first_idx;
  always_comb first_idx = lowest_idx(32'(ch_mask));

  assign ld_first = (first_idx < 0) ? '0 : CHW'(first_idx);
  assign ld_words = (col_count != '0) && (|ch_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNTW'(NCOLS);
      base_q <= '0;
      mask_q <= '0;
      tpos_q <= '0;
    end else if (load) begin
      cnt_q  <= clamp_cnt(col_count);
      base_q <= from_stop ? stop_col : '0;
      mask_q <= ch_mask;
      tpos_q <= tpos_in;
    end
  end

  assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(NCOLS));

endmodule

// File: rtl/colseq_chan_walk.sv
`timescale 1ns/1ps
module colseq_chan_walk #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [CHW-1:0] cur,
  output logic [CHW-1:0] first_ch,
  output logic [CHW-1:0] nxt_ch,
  output logic           has_next,
  output logic           any_en
);
  import colseq_pkg::*;

  logic [NCH-1:0] above;
  for (genvar i = 0; i < NCH; i++) begin : g_above
    assign above[i] = mask[i] && (i > int'(cur));
  end

  int f_idx, n_idx;
  always_comb begin
    f_idx = lowest_idx(32'(mask));
    n_idx = lowest_idx(32'(above));
  end

  assign first_ch = (f_idx < 0) ? '0 : CHW'(f_idx);
  assign nxt_ch   = (n_idx < 0) ? '0 : CHW'(n_idx);
  assign has_next = (n_idx >= 0);
  assign any_en   = |mask;

endmodule

// File: rtl/colseq_col_ctr.sv
`timescale 1ns/1ps
module colseq_col_ctr #(
  parameter int NCOLS = 128,
  parameter int CNTW  = 8,
  localparam int COLW = $clog2(NCOLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            step,
  input  logic [COLW-1:0] base,
  output logic [CNTW-1:0] k_q,
  output logic [COLW-1:0] col_addr
);

  function automatic logic [COLW-1:0] wrap_add(input logic [COLW-1:0] b,
                                               input logic [CNTW-1:0] k);
    logic [COLW:0] s;
    s = {1'b0, b} + {1'b0, k[COLW-1:0]};
    return s[COLW-1:0];
  endfunction

  assign col_addr = wrap_add(base, k_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     k_q <= '0;
    else if (clear) k_q <= '0;
    else if (step)  k_q <= k_q + 1'b1;
  end

endmodule

// File: rtl/col_readout_seq.sv
`timescale 1ns/1ps
module col_readout_seq #(
  parameter int NCOLS = 128,
  parameter int NCH   = 4,
  parameter int CNTW  = 8,
  parameter int TPW   = 8,
  localparam int COLW = $clog2(NCOLS),
  localparam int CHW  = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [COLW-1:0] stop_col,
  input  logic [CNTW-1:0] col_count,
  input  logic            skip_tpos,
  input  logic            from_stop,
  input  logic [NCH-1:0]  ch_mask,
  input  logic [TPW-1:0]  tpos_in,
  input  logic            out_ready,
  output logic            out_valid,
  output logic            out_hdr,
  output logic [CHW-1:0]  out_chan,
  output logic [COLW-1:0] out_col,
  output logic [TPW-1:0]  out_tpos,
  output logic            done
);
  import colseq_pkg::*;

  seq_state_t state_q, state_d;

  logic [CNTW-1:0] cnt_q;
  logic [COLW-1:0] base_q;
  logic [NCH-1:0]  mask_q;
  logic [TPW-1:0]  tpos_q;
  logic            ld_words;
  logic [CHW-1:0]  ld_first;
  logic [CHW-1:0]  cur_ch_q;
  logic [CHW-1:0]  first_ch, nxt_ch;
  logic            has_next, any_en;
  logic [CNTW-1:0] k_q;
  logic [COLW-1:0] col_addr;

  // named events
  logic idle, load, word_acc, last_word, col_step, q_words;

  assign idle      = (state_q == S_IDLE);
  assign load      = start && idle;
  assign out_valid = (state_q == S_HDR) || (state_q == S_DATA);
  assign word_acc  = out_valid && out_ready;
  assign q_words   = (cnt_q != '0) && any_en;
  assign last_word = (state_q == S_DATA) && !has_next && (k_q == cnt_q - 1'b1);
  assign col_step  = word_acc && (state_q == S_DATA) && !has_next && !last_word;

  colseq_cfg #(.NCOLS(NCOLS), .NCH(NCH), .CNTW(CNTW), .TPW(TPW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .stop_col(stop_col), .col_count(col_count), .from_stop(from_stop),
    .ch_mask(ch_mask), .tpos_in(tpos_in),
    .cnt_q(cnt_q), .base_q(base_q), .mask_q(mask_q), .tpos_q(tpos_q),
    .ld_words(ld_words), .ld_first(ld_first)
  );

  colseq_chan_walk #(.NCH(NCH)) u_walk (
    .mask(mask_q), .cur(cur_ch_q),
    .first_ch(first_ch), .nxt_ch(nxt_ch),
    .has_next(has_next), .any_en(any_en)
  );

  colseq_col_ctr #(.NCOLS(NCOLS), .CNTW(CNTW)) u_col (
    .clk(clk), .rst_n(rst_n), .clear(load), .step(col_step),
    .base(base_q), .k_q(k_q), .col_addr(col_addr)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (load) begin
        if (!skip_tpos)    state_d = S_HDR;
        else if (ld_words) state_d = S_DATA;
        else               state_d = S_FIN;
      end
      S_HDR:  if (word_acc) state_d = q_words ? S_DATA : S_FIN;
      S_DATA: if (word_acc && last_word) state_d = S_FIN;
      S_FIN:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cur_ch_q <= '0;
    end else begin
      state_q <= state_d;
      if (load)
        cur_ch_q <= ld_first;
      else if (word_acc && state_q == S_DATA)
        cur_ch_q <= has_next ? nxt_ch : first_ch;
    end
  end

  assign out_hdr  = (state_q == S_HDR);
  assign out_chan = cur_ch_q;
  assign out_col  = col_addr;
  assign out_tpos = tpos_q;
  assign done     = (state_q == S_FIN);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_hdr, out_chan, out_col, out_tpos}));

  assert_chan_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hdr |-> mask_q[out_chan]);

  assert_col_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hdr |-> k_q < cnt_q);

  assert_hdr_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load && !skip_tpos |=> out_valid && out_hdr);

  assert_done_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_acc && last_word |=> done && !out_valid);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_ign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && start |=> $stable(cnt_q) && $stable(base_q) &&
      $stable(mask_q) && $stable(tpos_q));

endmodule

// File: tb/col_readout_seq_bench.sv
`timescale 1ns/1ps
module col_readout_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] stop_col = '0;
  logic [7:0] col_count = 8'd128;
  logic       skip_tpos = 1'b0;
  logic       from_stop = 1'b0;
  logic [3:0] ch_mask = 4'hF;
  logic [7:0] tpos_in = '0;
  logic       out_ready = 1'b0;
  logic       out_valid, out_hdr, done;
  logic [1:0] out_chan;
  logic [6:0] out_col;
  logic [7:0] out_tpos;

  int total = 0;
  int bad = 0;
  logic [7:0] lfsr = 8'hA5;

  always #2.5 clk = ~clk;

  col_readout_seq u_col_readout_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop_col(stop_col),
    .col_count(col_count), .skip_tpos(skip_tpos), .from_stop(from_stop),
    .ch_mask(ch_mask), .tpos_in(tpos_in), .out_ready(out_ready),
    .out_valid(out_valid), .out_hdr(out_hdr), .out_chan(out_chan),
    .out_col(out_col), .out_tpos(out_tpos), .done(done)
  );

  // {stop[28:22], count[21:14], skip[13], from_stop[12], mask[11:8], tpos[7:0]}
  localparam int NV = 9;
  localparam logic [28:0] VEC [NV] = '{
    {7'd0,   8'd128, 1'b0, 1'b0, 4'hF, 8'h5A},
    {7'd100, 8'd40,  1'b0, 1'b1, 4'h5, 8'h33},
    {7'd127, 8'd3,   1'b1, 1'b1, 4'h8, 8'h00},
    {7'd20,  8'd200, 1'b1, 1'b0, 4'h2, 8'h11},
    {7'd5,   8'd0,   1'b0, 1'b1, 4'hF, 8'hC3},
    {7'd5,   8'd0,   1'b1, 1'b1, 4'hF, 8'h77},
    {7'd9,   8'd10,  1'b0, 1'b1, 4'h0, 8'h9E},
    {7'd64,  8'd128, 1'b0, 1'b1, 4'hA, 8'hE1},
    {7'd9,   8'd1,   1'b1, 1'b1, 4'h1, 8'h42}
  };
  localparam string TAG [NV] = '{"R6", "R3", "R3", "R4", "R4", "R4", "R5", "R3", "R6"};

  bit e_hdr [0:600];
  int e_ch  [0:600];
  int e_col [0:600];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build_expect(input logic [28:0] v, output int n);
    int cc, base;
    n = 0;
    if (!v[13]) begin e_hdr[n] = 1'b1; e_ch[n] = 0; e_col[n] = 0; n++; end
    cc = (int'(v[21:14]) > 128) ? 128 : int'(v[21:14]);
    base = v[12] ? int'(v[28:22]) : 0;
    for (int k = 0; k < cc; k++)
      for (int c = 0; c < 4; c++)
        if (v[8 + c]) begin
          e_hdr[n] = 1'b0; e_ch[n] = c; e_col[n] = (base + k) % 128; n++;
        end
  endtask

  task automatic run_vec(input logic [28:0] v, input string tag, input bit poke);
    int n, got, cyc;
    bit seen_done, prev_last, stalled, poked;
    logic [17:0] saved;
    build_expect(v, n);
    @(negedge clk);
    stop_col = v[28:22]; col_count = v[21:14]; skip_tpos = v[13];
    from_stop = v[12]; ch_mask = v[11:8]; tpos_in = v[7:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0; cyc = 0; seen_done = 0; prev_last = (n == 0); stalled = 0; poked = 0;
    saved = '0;
    while (!seen_done && cyc < 3000) begin
      if (done) begin
        check(prev_last && got == n, "R8", "done timing / word count", got, n);
        seen_done = 1;
      end else begin
        if (stalled)
          check(out_valid && {out_hdr, out_chan, out_col, out_tpos} == saved,
                "R7", "word held under stall",
                int'({out_hdr, out_chan, out_col, out_tpos}), int'(saved));
        out_ready = lfsr[0] | lfsr[1];
        if (poke && got == 2 && !poked) begin
          start = 1'b1; col_count = 8'd3; ch_mask = 4'h1;
          skip_tpos = 1'b1; from_stop = 1'b0; tpos_in = 8'hFF;
          poked = 1;
        end else start = 1'b0;
        prev_last = 0;
        if (out_valid && out_ready) begin
          if (got >= n) check(0, tag, "extra word", got, n);
          else if (e_hdr[got])
            check(out_hdr && out_tpos == v[7:0], "R2", "header word",
                  int'({out_hdr, out_tpos}), int'({1'b1, v[7:0]}));
          else
            check(!out_hdr && int'(out_chan) == e_ch[got] && int'(out_col) == e_col[got],
                  tag, "data word ch*1000+col",
                  int'(out_chan) * 1000 + int'(out_col) + (out_hdr ? 100000 : 0),
                  e_ch[got] * 1000 + e_col[got]);
          prev_last = (got == n - 1);
          got++;
        end
        stalled = out_valid && !out_ready;
        saved = {out_hdr, out_chan, out_col, out_tpos};
        @(negedge clk);
        start = 1'b0;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        cyc++;
      end
    end
    if (!seen_done) check(0, "R8", "done never seen", got, n);
    @(negedge clk);
    check(!done && !out_valid, "R8", "done lasts one cycle",
          int'({done, out_valid}), 0);
    out_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R8 watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !done, "R1", "outputs in reset",
          int'({out_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !done, "R1", "outputs after reset",
          int'({out_valid, done}), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], TAG[i], 1'b0);

    // stray start mid-frame must not disturb the running frame
    run_vec({7'd100, 8'd40, 1'b0, 1'b1, 4'h5, 8'h33}, "R9", 1'b1);
    // clamp boundary at 129
    run_vec({7'd3, 8'd129, 1'b1, 1'b1, 4'h4, 8'h00}, "R4", 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule